// File: doc/BRIEF.md
# Sparsified Hit-Matrix Readout Controller

This block reads out a 32-row by 128-column binary hit matrix organised as 4x4-pixel macropixels (8 macropixel rows by 32 macropixel columns). Each macropixel has two private wires to the controller: a flag that says it holds at least one hit, and a freeze line that stops it from latching new hits. The readout is data-driven. When the controller is idle and any flag is up, it freezes exactly the flagged macropixels in one step and records a timestamp. It then walks only the pixel columns that belong to a fired macropixel column. It reads one column per clock, and each column delivers 32 row bits over shared row lines.

Each non-empty column is pushed into a local buffer as a single record, so up to 32 hits enter the buffer per clock. A bound on buffered hits stalls the sweep when a full column might not fit. An output stage zero-suppresses each record with a priority encoder. It emits one 20-bit word per set pixel on a valid/ready stream, giving the row, the column and the timestamp of the snapshot.

Top module: `hitmap_readout`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `mp_freeze` is all zero, `col_en` is low and `out_valid` is low. A reset in the middle of a sweep abandons that sweep.
- R2: When no sweep is in progress and `mp_hit` is non-zero at a clock edge, `mp_freeze` equals that `mp_hit` value after the edge. Bit index = macropixel_row*32 + macropixel_column, where a macropixel covers rows 4*mr..4*mr+3 and columns 4*mc..4*mc+3. Freeze bits only rise while all of them are clear.
- R3: A sweep strobes (`col_en` high with `col_sel`) exactly the four columns of every macropixel column holding a frozen macropixel, and no other column. Strobes come in strictly ascending column order, one per clock, with no idle cycle between them while the buffer has room.
- R4: The freeze bits of macropixel column k clear at the edge that reads column 4k+3. Other freeze bits stay set. Freeze bits change only on a strobe or on reset. After a sweep all freeze bits are clear.
- R5: Exactly one output word is emitted per hit pixel read in a sweep. Empty pixels produce no word.
- R6: Output word layout is row in bits [19:15], column in [14:8] and timestamp in [7:0]. Words come out in ascending column order, and by ascending row within a column. A word held with `out_ready` low stays unchanged.
- R7: A free-running 8-bit counter is 0 in the first cycle after reset and increments every clock. Every word of a sweep carries the counter value of the cycle in which the flags were sampled.
- R8: The buffer never holds more than 160 hits. A column is strobed only while at most 128 hits are held. With the output blocked and the whole matrix hit, exactly five columns are strobed before the sweep stalls, and it resumes once words drain.
- R9: A hit arriving during a sweep in a macropixel that is not frozen stays unfrozen and is reported by a later sweep with a later timestamp. A hit arriving in a frozen macropixel is discarded by the matrix and never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mp_hit | input | 256 | Per-macropixel hit-present flags |
| mp_freeze | output | 256 | Per-macropixel freeze lines, registered |
| col_en | output | 1 | Column read strobe; the column is captured and cleared at the next edge |
| col_sel | output | 7 | Index of the strobed column |
| row_bits | input | 32 | Hit bits of the strobed column, one per row |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 20 | Formatted hit word {row, column, timestamp} |

## Verification
Flags raised by a pixel update are frozen at the following edge, and the bench checks `mp_freeze` at the falling edge right after that edge. The first column strobe appears in the next cycle. A record reaches the output register two edges after its column is captured. A per-group freeze release is checked at the falling edge after the strobe of the group's last column. The timestamp is predicted from a bench cycle counter reset with the design: at the falling edge after the snapshot edge, the expected stamp is the count minus one. Word contents, word counts and strobe spacing are compared only after the stream has drained and a few idle cycles have passed. This makes the comparison independent of the output latency.

// File: rtl/hr_pkg.sv
package hr_pkg;
  // Default geometry of the readout; module parameters default to these.
  localparam int HR_ROWS     = 32;
  localparam int HR_COLS     = 128;
  localparam int HR_MPD      = 4;    // macropixel edge in pixels (power of two)
  localparam int HR_TS_W     = 8;
  localparam int HR_BUF_HITS = 160;
endpackage

// File: rtl/hr_sweep.sv
module hr_sweep #(
  parameter int ROWS  = hr_pkg::HR_ROWS,
  parameter int COLS  = hr_pkg::HR_COLS,
  parameter int MPD   = hr_pkg::HR_MPD,
  parameter int TS_W  = hr_pkg::HR_TS_W,
  localparam int MPR   = ROWS / MPD,
  localparam int MPC   = COLS / MPD,
  localparam int NMP   = MPR * MPC,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NMP-1:0]   mp_hit,
  input  logic             room,
  output logic [NMP-1:0]   mp_freeze,
  output logic             col_en,
  output logic [COL_W-1:0] col_sel,
  output logic [TS_W-1:0]  snap_ts
);
  localparam int SUB_W = $clog2(MPD);
  localparam int GRP_W = COL_W - SUB_W;

  logic [COLS-1:0]  pending;
  logic [COLS-1:0]  fired_cols;
  logic [MPC-1:0]   grp_any;
  logic [TS_W-1:0]  ts_ctr;
  logic [GRP_W-1:0] cur_grp;
  logic             busy, grp_last;

  // A macropixel column is due if any macropixel in it is flagged.
  always_comb begin
    grp_any = '0;
    for (int mr = 0; mr < MPR; mr++)
      grp_any = grp_any | mp_hit[mr*MPC +: MPC];
  end

  for (genvar mc = 0; mc < MPC; mc++) begin : g_expand
    assign fired_cols[mc*MPD +: MPD] = {MPD{grp_any[mc]}};
  end

  // Lowest pending column wins: ascending sweep order.
  always_comb begin
    col_sel = '0;
    for (int c = COLS-1; c >= 0; c--)
      if (pending[c]) col_sel = COL_W'(c);
  end

  assign busy     = |pending;
  assign col_en   = busy & room;
  assign cur_grp  = col_sel[COL_W-1:SUB_W];
  assign grp_last = &col_sel[SUB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      mp_freeze <= '0;
      ts_ctr    <= '0;
      snap_ts   <= '0;
    end else begin
      ts_ctr <= ts_ctr + 1'b1;
      if (!busy) begin
        if (|mp_hit) begin
          mp_freeze <= mp_hit;
          pending   <= fired_cols;
          snap_ts   <= ts_ctr;
        end
      end else if (room) begin
        pending[col_sel] <= 1'b0;
        if (grp_last)
          for (int mr = 0; mr < MPR; mr++)
            mp_freeze[mr*MPC + int'(cur_grp)] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hr_hitbuf.sv
module hr_hitbuf #(
  parameter int ROWS  = hr_pkg::HR_ROWS,
  parameter int COL_W = 7,
  parameter int TS_W  = hr_pkg::HR_TS_W,
  parameter int DEPTH = hr_pkg::HR_BUF_HITS,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [ROWS-1:0]  push_bits,
  input  logic [COL_W-1:0] push_col,
  input  logic [TS_W-1:0]  push_ts,
  input  logic             pop,
  input  logic             hit_out,
  output logic             room,
  output logic             rec_avail,
  output logic [ROWS-1:0]  head_bits,
  output logic [COL_W-1:0] head_col,
  output logic [TS_W-1:0]  head_ts,
  output logic [CNT_W-1:0] hit_cnt
);
  localparam int REC_W = ROWS + COL_W + TS_W;
  localparam int PTR_W = $clog2(DEPTH);

  // One record per non-empty column; never more records than hits.
  logic [REC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] rec_cnt, push_n;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {push_bits, push_col, push_ts};

  assign {head_bits, head_col, head_ts} = mem[rd_ptr];

  always_comb begin
    push_n = '0;
    for (int r = 0; r < ROWS; r++)
      push_n = push_n + CNT_W'(push_bits[r]);
  end

  assign rec_avail = (rec_cnt != '0);
  assign room      = (hit_cnt <= CNT_W'(DEPTH - ROWS));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rec_cnt <= '0;
      hit_cnt <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      rec_cnt <= rec_cnt + CNT_W'(push) - CNT_W'(pop);
      hit_cnt <= hit_cnt + (push ? push_n : '0) - CNT_W'(hit_out);
    end
  end
endmodule

// File: rtl/hr_emit.sv
module hr_emit #(
  parameter int ROWS  = hr_pkg::HR_ROWS,
  parameter int COL_W = 7,
  parameter int TS_W  = hr_pkg::HR_TS_W,
  localparam int ROW_W = $clog2(ROWS),
  localparam int W_W   = ROW_W + COL_W + TS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_avail,
  input  logic [ROWS-1:0]  head_bits,
  input  logic [COL_W-1:0] head_col,
  input  logic [TS_W-1:0]  head_ts,
  output logic             pop,
  output logic             hit_out,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [W_W-1:0]   out_word
);
  logic             work_v;
  logic [ROWS-1:0]  work_bits, rest_bits;
  logic [COL_W-1:0] work_col;
  logic [TS_W-1:0]  work_ts;
  logic [ROW_W-1:0] low_row;

  // Zero suppression: lowest remaining row first.
  always_comb begin
    low_row = '0;
    for (int r = ROWS-1; r >= 0; r--)
      if (work_bits[r]) low_row = ROW_W'(r);
    rest_bits = work_bits;
    rest_bits[low_row] = 1'b0;
  end

  assign pop     = !work_v && rec_avail;
  assign hit_out = work_v && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      work_v    <= 1'b0;
      work_bits <= '0;
      work_col  <= '0;
      work_ts   <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      if (pop) begin
        work_v    <= 1'b1;
        work_bits <= head_bits;
        work_col  <= head_col;
        work_ts   <= head_ts;
      end
      if (hit_out) begin
        out_word  <= {low_row, work_col, work_ts};
        out_valid <= 1'b1;
        work_bits <= rest_bits;
        if (rest_bits == '0) work_v <= 1'b0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hitmap_readout.sv
module hitmap_readout #(
  parameter int ROWS     = hr_pkg::HR_ROWS,
  parameter int COLS     = hr_pkg::HR_COLS,
  parameter int MPD      = hr_pkg::HR_MPD,
  parameter int TS_W     = hr_pkg::HR_TS_W,
  parameter int BUF_HITS = hr_pkg::HR_BUF_HITS,
  localparam int NMP   = (ROWS / MPD) * (COLS / MPD),
  localparam int COL_W = $clog2(COLS),
  localparam int W_W   = $clog2(ROWS) + COL_W + TS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NMP-1:0]   mp_hit,
  output logic [NMP-1:0]   mp_freeze,
  output logic             col_en,
  output logic [COL_W-1:0] col_sel,
  input  logic [ROWS-1:0]  row_bits,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W_W-1:0]   out_word
);
  localparam int CNT_W = $clog2(BUF_HITS + 1);

  logic             room, push, pop, hit_out, rec_avail;
  logic [TS_W-1:0]  snap_ts, head_ts;
  logic [ROWS-1:0]  head_bits;
  logic [COL_W-1:0] head_col;
  logic [CNT_W-1:0] buf_hits;

  hr_sweep #(.ROWS(ROWS), .COLS(COLS), .MPD(MPD), .TS_W(TS_W)) u_sweep (
    .clk(clk), .rst(rst), .mp_hit(mp_hit), .room(room),
    .mp_freeze(mp_freeze), .col_en(col_en), .col_sel(col_sel), .snap_ts(snap_ts)
  );

  assign push = col_en && (|row_bits);

  hr_hitbuf #(.ROWS(ROWS), .COL_W(COL_W), .TS_W(TS_W), .DEPTH(BUF_HITS)) u_buf (
    .clk(clk), .rst(rst), .push(push), .push_bits(row_bits), .push_col(col_sel),
    .push_ts(snap_ts), .pop(pop), .hit_out(hit_out), .room(room),
    .rec_avail(rec_avail), .head_bits(head_bits), .head_col(head_col),
    .head_ts(head_ts), .hit_cnt(buf_hits)
  );

  hr_emit #(.ROWS(ROWS), .COL_W(COL_W), .TS_W(TS_W)) u_emit (
    .clk(clk), .rst(rst), .rec_avail(rec_avail), .head_bits(head_bits),
    .head_col(head_col), .head_ts(head_ts), .pop(pop), .hit_out(hit_out),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word)
  );
endmodule

// File: rtl/hitmap_readout_chk.sv
module hitmap_readout_chk #(
  parameter int ROWS     = 32,
  parameter int COLS     = 128,
  parameter int MPD      = 4,
  parameter int TS_W     = 8,
  parameter int BUF_HITS = 160,
  localparam int MPR   = ROWS / MPD,
  localparam int MPC   = COLS / MPD,
  localparam int NMP   = MPR * MPC,
  localparam int COL_W = $clog2(COLS),
  localparam int W_W   = $clog2(ROWS) + COL_W + TS_W,
  localparam int CNT_W = $clog2(BUF_HITS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [NMP-1:0]   mp_freeze,
  input logic             col_en,
  input logic [COL_W-1:0] col_sel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W_W-1:0]   out_word,
  input logic [CNT_W-1:0] buf_hits
);
  localparam int SUB_W = $clog2(MPD);
  logic grp_frozen;

  always_comb begin
    grp_frozen = 1'b0;
    for (int mr = 0; mr < MPR; mr++)
      grp_frozen = grp_frozen | mp_freeze[mr*MPC + int'(col_sel >> SUB_W)];
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    buf_hits <= CNT_W'(BUF_HITS));

  assert_col_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    col_en |-> grp_frozen);

  assert_col_ascend_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(col_en) && col_en) |-> (col_sel > $past(col_sel)));

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  assert_freeze_snap_R2: assert property (@(posedge clk) disable iff (rst)
    (|(mp_freeze & ~$past(mp_freeze))) |-> ($past(mp_freeze) == '0));

  assert_release_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    (|($past(mp_freeze) & ~mp_freeze)) |-> $past(col_en));
endmodule

bind hitmap_readout hitmap_readout_chk #(
  .ROWS(ROWS), .COLS(COLS), .MPD(MPD), .TS_W(TS_W), .BUF_HITS(BUF_HITS)
) u_chk (
  .clk(clk), .rst(rst), .mp_freeze(mp_freeze), .col_en(col_en),
  .col_sel(col_sel), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .buf_hits(buf_hits)
);

// File: tb/hitmap_readout_bench.sv
module hitmap_readout_bench;
  localparam int ROWS = 32, COLS = 128, MPD = 4, MPC = 32, NMP = 256;
  localparam int NVEC = 6;
  // Rectangle of pixels per vector: {row, col, height, width}
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd0,  7'd0,   6'd1,  8'd1},
    {5'd31, 7'd127, 6'd1,  8'd1},
    {5'd5,  7'd9,   6'd3,  8'd2},
    {5'd2,  7'd2,   6'd4,  8'd4},
    {5'd0,  7'd60,  6'd32, 8'd1},
    {5'd8,  7'd30,  6'd2,  8'd70}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst = 1'b1, out_ready = 1'b1;
  logic [NMP-1:0]  mp_hit, mp_freeze;
  logic            col_en, out_valid;
  logic [6:0]      col_sel;
  logic [31:0]     row_bits;
  logic [19:0]     out_word;

  hitmap_readout u_hitmap_readout (
    .clk(clk), .rst(rst), .mp_hit(mp_hit), .mp_freeze(mp_freeze),
    .col_en(col_en), .col_sel(col_sel), .row_bits(row_bits),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  // Behavioural matrix: frozen macropixels ignore new hits; a strobed column is cleared.
  logic [COLS-1:0] pix [ROWS];
  logic [COLS-1:0] inj [ROWS];
  initial for (int r = 0; r < ROWS; r++) inj[r] = '0;

  always @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] nx;
      nx = pix[r];
      for (int c = 0; c < COLS; c++)
        if (inj[r][c] && !mp_freeze[(r/MPD)*MPC + c/MPD]) nx[c] = 1'b1;
      if (col_en) nx[col_sel] = 1'b0;
      pix[r] <= rst ? '0 : nx;
    end
  end

  always_comb begin
    for (int m = 0; m < NMP; m++) begin
      mp_hit[m] = 1'b0;
      for (int i = 0; i < MPD; i++)
        for (int j = 0; j < MPD; j++)
          mp_hit[m] = mp_hit[m] | pix[(m/MPC)*MPD + i][(m%MPC)*MPD + j];
    end
    for (int r = 0; r < ROWS; r++) row_bits[r] = pix[r][col_sel];
  end

  // Monitor, sampled on falling edges
  int cyc = 0;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  logic [19:0]    cap [8192];
  int             st_cyc [1024];
  logic [7:0]     sw_ts [64];
  int             cap_n = 0, st_n = 0, sw_n = 0;
  logic [NMP-1:0] prev_frz = '0;

  always @(negedge clk) begin
    if (rst) prev_frz = '0;
    else begin
      if (out_valid && out_ready) begin cap[cap_n] = out_word; cap_n = cap_n + 1; end
      if (col_en) begin st_cyc[st_n] = cyc; st_n = st_n + 1; end
      if (mp_freeze != '0 && prev_frz == '0) begin
        sw_ts[sw_n] = 8'(cyc - 1); sw_n = sw_n + 1;
      end
      prev_frz = mp_freeze;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic inject(input int r0, input int c0, input int h, input int w);
    for (int r = r0; r < r0 + h; r++)
      for (int c = c0; c < c0 + w; c++) inj[r][c] = 1'b1;
    tick();
    for (int r = 0; r < ROWS; r++) inj[r] = '0;
  endtask

  function automatic logic [NMP-1:0] rect_mask(input int r0, input int c0, input int h, input int w);
    logic [NMP-1:0] m = '0;
    for (int r = r0; r < r0 + h; r++)
      for (int c = c0; c < c0 + w; c++) m[(r/MPD)*MPC + c/MPD] = 1'b1;
    return m;
  endfunction

  function automatic int grp_count(input int c0, input int w);
    return (c0 + w - 1)/MPD - c0/MPD + 1;
  endfunction

  task automatic drain(input int base, input int n);
    for (int k = 0; k < 20000; k++) begin
      if (cap_n - base >= n && mp_freeze == '0 && !out_valid) break;
      tick();
    end
    repeat (10) tick();
  endtask

  // Compare a rectangle's words: column-major, ascending row, one stamp.
  task automatic check_words(input int base, input int r0, input int c0, input int h, input int w, input logic [7:0] ts);
    check(cap_n - base == h*w, "R5 word count", cap_n - base, h*w);
    for (int i = 0; i < h*w && i < cap_n - base; i++) begin
      logic [19:0] e;
      e = {5'(r0 + i % h), 7'(c0 + i / h), ts};
      check(cap[base + i] == e, "R6/R7 word", cap[base + i], e);
    end
  endtask

  initial begin
    int bc, bs, bw;
    rst = 1'b1;
    repeat (4) tick();
    check(mp_freeze == '0 && !col_en && !out_valid, "R1 in reset", {mp_freeze, col_en, out_valid}, 0);
    rst = 1'b0;
    tick();
    check(mp_freeze == '0 && !col_en && !out_valid && out_word == '0, "R1 after reset",
          {mp_freeze, col_en, out_valid, out_word}, 0);

    // Table-driven vectors
    for (int v = 0; v < NVEC; v++) begin
      int r0, c0, h, w, ns;
      r0 = int'(VEC[v][25:21]); c0 = int'(VEC[v][20:14]);
      h  = int'(VEC[v][13:8]);  w  = int'(VEC[v][7:0]);
      bc = cap_n; bs = st_n; bw = sw_n;
      inject(r0, c0, h, w);
      @(posedge clk); @(negedge clk);
      check(mp_freeze == rect_mask(r0, c0, h, w), "R2 freeze snapshot", mp_freeze, rect_mask(r0, c0, h, w));
      drain(bc, h*w);
      check(sw_n - bw == 1, "R7 one sweep", sw_n - bw, 1);
      check_words(bc, r0, c0, h, w, sw_ts[bw]);
      ns = st_n - bs;
      check(ns == MPD*grp_count(c0, w), "R3 strobe count", ns, MPD*grp_count(c0, w));
      if (ns > 0)
        check(st_cyc[st_n-1] - st_cyc[bs] == ns - 1, "R3 back-to-back strobes", st_cyc[st_n-1] - st_cyc[bs], ns - 1);
      check(mp_freeze == '0, "R4 all released", mp_freeze, 0);
    end

    // R4: per-group release, groups 0 and 5
    bc = cap_n;
    inject(0, 0, 1, 1);   // placeholder replaced below
    drain(bc, 1);
    bc = cap_n;
    for (int r = 0; r < ROWS; r++) inj[r] = '0;
    inj[1][2] = 1'b1; inj[9][21] = 1'b1;
    tick();
    for (int r = 0; r < ROWS; r++) inj[r] = '0;
    @(posedge clk);                       // snapshot edge
    repeat (4) @(posedge clk);            // columns 0..3 read
    @(negedge clk);
    check(mp_freeze[0] == 1'b0 && mp_freeze[2*MPC + 5] == 1'b1, "R4 group release",
          {mp_freeze[0], mp_freeze[2*MPC + 5]}, 2'b01);
    drain(bc, 2);
    check(cap_n - bc == 2, "R4 words after release", cap_n - bc, 2);

    // R9: hit during sweep in unfrozen and frozen macropixels
    bc = cap_n; bw = sw_n;
    inject(0, 0, 1, 1);
    @(posedge clk); #2;                   // one edge after snapshot
    inj[10][50] = 1'b1; inj[1][1] = 1'b1;
    tick();
    for (int r = 0; r < ROWS; r++) inj[r] = '0;
    @(negedge clk);
    check(mp_freeze[2*MPC + 12] == 1'b0, "R9 late hit not frozen", mp_freeze[2*MPC + 12], 0);
    drain(bc, 2);
    check(cap_n - bc == 2, "R9 frozen hit discarded", cap_n - bc, 2);
    check(sw_n - bw == 2, "R9 second sweep", sw_n - bw, 2);
    check(cap[bc] == {5'd0, 7'd0, sw_ts[bw]}, "R9 first word", cap[bc], {5'd0, 7'd0, sw_ts[bw]});
    check(cap[bc+1] == {5'd10, 7'd50, sw_ts[bw+1]} && sw_ts[bw+1] != sw_ts[bw], "R9 later stamp",
          cap[bc+1], {5'd10, 7'd50, sw_ts[bw+1]});

    // R8: full matrix with blocked output
    bc = cap_n; bs = st_n;
    out_ready = 1'b0;
    inject(0, 0, ROWS, COLS);
    repeat (60) tick();
    check(st_n - bs == 5, "R8 stall after five columns", st_n - bs, 5);
    check(out_valid == 1'b1 && cap_n == bc, "R8 word held", {out_valid, 32'(cap_n - bc)}, {1'b1, 32'd0});
    out_ready = 1'b1;
    drain(bc, ROWS*COLS);
    check(st_n - bs == COLS, "R8 resumed sweep", st_n - bs, COLS);
    check_words(bc, 0, 0, ROWS, COLS, sw_ts[sw_n-1]);

    // R1: reset in mid sweep
    bc = cap_n;
    inject(0, 64, 32, 8);
    @(posedge clk); @(posedge clk); #2;
    rst = 1'b1;
    tick(); tick();
    check(mp_freeze == '0 && !out_valid && !col_en, "R1 mid-sweep reset", {mp_freeze, out_valid, col_en}, 0);
    rst = 1'b0;
    repeat (40) tick();
    check(cap_n == bc && mp_freeze == '0, "R1 sweep abandoned", cap_n - bc, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog (R1-R9 run hung): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end
endmodule